// File: doc/BRIEF.md
# Debug Hart Handshake Unit

This unit is a small memory-mapped slave that sits inside a debug module. Processor cores (harts) that enter debug mode run a fixed ROM, and that ROM talks to this unit only through loads and stores at fixed offsets. A hart reports that it has halted by storing its own ID at one offset, and that it is resuming by storing its ID at another. A store to a third offset signals an exception taken in debug mode, and a store to a fourth tells the unit that the released hart has left its polling loop. While halted, each hart polls its own go byte. Once released, it jumps through a single instruction word that the unit rewrites for each release.

On the debugger side, a request port names one hart and a destination: the abstract command area, the program buffer, or the ROM's resume entry. The unit accepts a request only when it is safe to do so. It first encodes an unconditional jump to the chosen destination into the jump word. One cycle later it raises the go byte of the chosen hart. The unit drives a vector of halted harts and a sticky exception flag back to the debugger.

Top module: `dbg_hart_handshake`

## Requirements
- R1: A write with any byte strobe set to word offset 0x100 whose data is a hart ID below NUM_HARTS sets that hart's halted bit on the next clock. Rewriting the same ID leaves the state unchanged, and IDs of NUM_HARTS or more are ignored.
- R2: A write to offset 0x108 whose data is a valid hart ID clears that hart's halted bit on the next clock.
- R3: A write to offset 0x10C sets the exception flag on the next clock. The flag is cleared when a debugger request is accepted. If both happen in the same cycle, the set wins.
- R4: Reads are combinational and word-aligned (address bits 1:0 are ignored). In the go region starting at 0x400, byte lane k of the word at 0x400+4m is the go byte of hart 4m+k. That byte reads 0x01 for the released hart and 0x00 otherwise, and at most one go byte is nonzero at any time.
- R5: A write to offset 0x104 clears the pending go byte on the next clock.
- R6: Offset 0x300 reads a JAL instruction with rd=x0. Its fields are opcode 0x6F in bits 6:0, rd=0 in bits 11:7, and imm[19:12] in bits 19:12, imm[11] in bit 20, imm[10:1] in bits 30:21 and imm[20] in bit 31. The offset is measured from 0x300 to the target. Destination code 0 targets ABS_BASE, code 1 targets PBUF_BASE, and codes 2 and 3 target the resume entry 0x804. After reset the word targets 0x804.
- R7: When a request is accepted in cycle T, the jump word changes at the clock ending cycle T. The go byte of the selected hart turns nonzero only at the following clock.
- R8: `req_busy` is high when the selected hart is not halted, when its ID is out of range, when a go byte is set, or while a release is in flight. A request made while busy changes nothing.
- R9: Reads of any other offset return zero. Writes to offsets other than the four store offsets, and writes with no strobe set, change nothing.
- R10: After reset, the halted vector is zero, the exception flag is low and no go byte is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable of the hart-side port |
| bus_addr | input | 12 | Byte address within the unit |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| req_valid | input | 1 | Debugger release request |
| req_hart | input | HID_W | Hart selected by the request |
| req_dest | input | 2 | Destination code (0 abstract, 1 program buffer, 2 or 3 resume) |
| req_busy | output | 1 | Request cannot be accepted this cycle |
| halted | output | NUM_HARTS | Halted status, one bit per hart |
| exc_flag | output | 1 | Exception reported in debug mode |

## Verification
The hardest cases to reach are the ones where a hart store and a debugger request land in the same cycle. Examples are an exception store on the exact cycle a request is accepted, and a going store while a release is still between its jump-word write and its go-byte write. The stimulus reaches these by issuing the request and the store together from the same drive step, right after the previous release has fully finished. A behavioural model then predicts every read, busy and status value each cycle, including the single cycle in which the new jump word is visible but the go byte is still zero.

// File: rtl/dbg_hs_pkg.sv
package dbg_hs_pkg;

    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_HALTED   = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_GOING    = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_RESUMING = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_EXCEPT   = 12'h10C;
    localparam logic [ADDR_W-1:0] OFF_JUMP     = 12'h300;
    localparam logic [ADDR_W-1:0] OFF_GO       = 12'h400;
    localparam logic [ADDR_W-1:0] RESUME_ENTRY = 12'h804;

    typedef enum logic [1:0] {
        DEST_ABSTRACT = 2'd0,
        DEST_PROGBUF  = 2'd1,
        DEST_RESUME   = 2'd2,
        DEST_RESUME2  = 2'd3
    } dest_e;

    typedef struct packed {
        logic halt;
        logic going;
        logic resume;
        logic except;
    } store_t;

    // Unconditional jump, rd = x0, PC-relative from 'from' to 'to'.
    function automatic logic [31:0] jal_x0(input logic [ADDR_W-1:0] from,
                                           input logic [ADDR_W-1:0] to);
        logic [20:0] off;
        off = {9'd0, to} - {9'd0, from};
        return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'h6F};
    endfunction

endpackage

// File: rtl/dbg_hs_status.sv
module dbg_hs_status #(
    parameter int unsigned NUM_HARTS = 4,
    localparam int unsigned HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 halt_set,
    input  logic                 resume_clr,
    input  logic [HID_W-1:0]     hart_id,
    input  logic                 exc_set,
    input  logic                 exc_clr,
    output logic [NUM_HARTS-1:0] halted_q,
    output logic                 exc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q <= '0;
            exc_q    <= 1'b0;
        end else begin
            if (halt_set)
                halted_q[hart_id] <= 1'b1;
            else if (resume_clr)
                halted_q[hart_id] <= 1'b0;
            if (exc_set)
                exc_q <= 1'b1;
            else if (exc_clr)
                exc_q <= 1'b0;
        end
    end

    p_halt_sets_r1: assert property (@(posedge clk) disable iff (rst)
        halt_set |=> halted_q[$past(hart_id)]);

    p_resume_clears_r2: assert property (@(posedge clk) disable iff (rst)
        resume_clr |=> !halted_q[$past(hart_id)]);

    p_exc_latch_r3: assert property (@(posedge clk) disable iff (rst)
        exc_set |=> exc_q);

endmodule

// File: rtl/dbg_hs_release.sv
module dbg_hs_release
    import dbg_hs_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    localparam int unsigned HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic [HID_W-1:0]     acc_hart,
    input  logic [ADDR_W-1:0]    acc_target,
    input  logic                 going_wr,
    output logic [NUM_HARTS-1:0] go_q,
    output logic [31:0]          jump_q,
    output logic                 inflight
);

    logic             stage_v;
    logic [HID_W-1:0] stage_hart;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_v    <= 1'b0;
            stage_hart <= '0;
            go_q       <= '0;
            jump_q     <= jal_x0(OFF_JUMP, RESUME_ENTRY);
        end else begin
            stage_v <= accept;
            if (accept) begin
                stage_hart <= acc_hart;
                jump_q     <= jal_x0(OFF_JUMP, acc_target);
            end
            if (stage_v) begin
                go_q             <= '0;
                go_q[stage_hart] <= 1'b1;
            end else if (going_wr) begin
                go_q <= '0;
            end
        end
    end

    assign inflight = stage_v;

    p_single_go_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_q));

    p_word_before_go_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(|go_q) |-> $stable(jump_q));

    p_going_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (going_wr && !stage_v) |=> (go_q == '0));

endmodule

// File: rtl/dbg_hs_rdmux.sv
module dbg_hs_rdmux
    import dbg_hs_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    localparam int unsigned GO_SPAN = ((NUM_HARTS + 3) / 4) * 4
) (
    input  logic [ADDR_W-1:0]    word_addr,
    input  logic [31:0]          jump_word,
    input  logic [NUM_HARTS-1:0] go_vec,
    output logic [31:0]          rdata
);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rdata = '0;
        rel   = word_addr - OFF_GO;
        if (word_addr == OFF_JUMP) begin
            rdata = jump_word;
        end else if (word_addr >= OFF_GO && rel < ADDR_W'(GO_SPAN)) begin
            for (int k = 0; k < 4; k++) begin
                for (int h = 0; h < NUM_HARTS; h++) begin
                    if (32'(rel) + 32'(k) == 32'(h) && go_vec[h])
                        rdata[8*k] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dbg_hart_handshake.sv
module dbg_hart_handshake
    import dbg_hs_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter logic [11:0] ABS_BASE  = 12'h320,
    parameter logic [11:0] PBUF_BASE = 12'h340,
    localparam int unsigned HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 req_valid,
    input  logic [HID_W-1:0]     req_hart,
    input  logic [1:0]           req_dest,
    output logic                 req_busy,
    output logic [NUM_HARTS-1:0] halted,
    output logic                 exc_flag
);

    logic [ADDR_W-1:0]    waddr;
    logic                 wr, id_ok;
    store_t               st;
    logic [NUM_HARTS-1:0] go_vec;
    logic [31:0]          jump_word;
    logic                 inflight, accept, hart_ok;
    logic [ADDR_W-1:0]    target;
    dest_e                dest;

    assign waddr = {bus_addr[ADDR_W-1:2], 2'b00};
    assign wr    = bus_we && (bus_be != 4'b0000);
    assign id_ok = bus_wdata < 32'(NUM_HARTS);

    always_comb begin
        st.halt   = wr && waddr == OFF_HALTED   && id_ok;
        st.going  = wr && waddr == OFF_GOING;
        st.resume = wr && waddr == OFF_RESUMING && id_ok;
        st.except = wr && waddr == OFF_EXCEPT;
    end

    assign dest    = dest_e'(req_dest);
    assign hart_ok = (32'(req_hart) < 32'(NUM_HARTS)) && halted[req_hart];
    assign req_busy = !hart_ok || (go_vec != '0) || inflight;
    assign accept   = req_valid && !req_busy;

    always_comb begin
        case (dest)
            DEST_ABSTRACT: target = ABS_BASE;
            DEST_PROGBUF:  target = PBUF_BASE;
            default:       target = RESUME_ENTRY;
        endcase
    end

    dbg_hs_status #(.NUM_HARTS(NUM_HARTS)) u_status (
        .clk        (clk),
        .rst        (rst),
        .halt_set   (st.halt),
        .resume_clr (st.resume),
        .hart_id    (bus_wdata[HID_W-1:0]),
        .exc_set    (st.except),
        .exc_clr    (accept),
        .halted_q   (halted),
        .exc_q      (exc_flag)
    );

    dbg_hs_release #(.NUM_HARTS(NUM_HARTS)) u_release (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .acc_hart   (req_hart),
        .acc_target (target),
        .going_wr   (st.going),
        .go_q       (go_vec),
        .jump_q     (jump_word),
        .inflight   (inflight)
    );

    dbg_hs_rdmux #(.NUM_HARTS(NUM_HARTS)) u_rdmux (
        .word_addr (waddr),
        .jump_word (jump_word),
        .go_vec    (go_vec),
        .rdata     (bus_rdata)
    );

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_busy) |=> $stable(jump_word));

    p_go_needs_halt_r8: assert property (@(posedge clk) disable iff (rst)
        accept |-> halted[req_hart]);

endmodule

// File: tb/dbg_hart_handshake_test.sv
module dbg_hart_handshake_test;

    localparam int NH = 4;
    localparam logic [11:0] ABS  = 12'h320;
    localparam logic [11:0] PBUF = 12'h340;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic [1:0]  req_hart;
    logic [1:0]  req_dest;
    logic        req_busy;
    logic [NH-1:0] halted;
    logic        exc_flag;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    dbg_hart_handshake #(.NUM_HARTS(NH), .ABS_BASE(ABS), .PBUF_BASE(PBUF)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_hart(req_hart), .req_dest(req_dest), .req_busy(req_busy),
        .halted(halted), .exc_flag(exc_flag)
    );

    // Reference model state
    bit          m_halted [NH];
    bit          m_exc;
    int          m_go;
    int          m_stage;
    logic [31:0] m_jump;

    function automatic logic [31:0] enc_jal(int tgt);
        int d;
        logic [20:0] o;
        d = tgt - 'h300;
        o = d[20:0];
        return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
    endfunction

    function automatic int dest_addr(int code);
        if (code == 0) return int'(ABS);
        if (code == 1) return int'(PBUF);
        return 'h804;
    endfunction

    function automatic bit exp_busy();
        return !m_halted[req_hart] || m_go >= 0 || m_stage >= 0;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        logic [31:0] r;
        int w;
        r = 0;
        w = a & ~3;
        if (w == 'h300) r = m_jump;
        else if (w == 'h400) begin
            for (int k = 0; k < 4; k++)
                if (k == m_go) r[8*k +: 8] = 8'h01;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [NH-1:0] hv;
        string rtag;
        for (int i = 0; i < NH; i++) hv[i] = m_halted[i];
        chk("R1/R2/R10 halted", 32'(halted), 32'(hv));
        chk("R3 exc_flag", 32'(exc_flag), 32'(m_exc));
        chk("R8 req_busy", 32'(req_busy), 32'(exp_busy()));
        if ((bus_addr & 12'hFFC) == 12'h300) rtag = "R6 jump word";
        else if ((bus_addr & 12'hFFC) == 12'h400) rtag = "R4/R7 go bytes";
        else rtag = "R9 unmapped read";
        chk(rtag, bus_rdata, exp_rd(int'(bus_addr)));
    endtask

    task automatic model_step();
        bit acc, wr;
        int w, nstage, ngo;
        acc = req_valid && !exp_busy();
        wr  = bus_we && (bus_be != 0);
        w   = int'(bus_addr) & ~3;
        nstage = acc ? int'(req_hart) : -1;
        ngo = m_go;
        if (m_stage >= 0) ngo = m_stage;
        else if (wr && w == 'h104) ngo = -1;
        if (acc) begin
            m_jump = enc_jal(dest_addr(int'(req_dest)));
            m_exc  = 0;
        end
        if (wr && w == 'h10C) m_exc = 1;
        if (wr && w == 'h100 && bus_wdata < NH) m_halted[bus_wdata] = 1;
        if (wr && w == 'h108 && bus_wdata < NH) m_halted[bus_wdata] = 0;
        m_go = ngo;
        m_stage = nstage;
    endtask

    task automatic idle();
        bus_we = 0; bus_addr = 12'h000; bus_be = 0; bus_wdata = 0;
        req_valid = 0; req_hart = 0; req_dest = 0;
    endtask

    task automatic cyc();
        #1;
        compare();
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic store(logic [11:0] a, logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_be = 4'hF; bus_wdata = d;
        cyc();
    endtask

    task automatic rd(logic [11:0] a);
        bus_addr = a;
        cyc();
    endtask

    task automatic req(int h, int d);
        req_valid = 1; req_hart = 2'(h); req_dest = 2'(d);
        cyc();
    endtask

    initial begin
        #2000000;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < NH; i++) m_halted[i] = 0;
        m_exc = 0; m_go = -1; m_stage = -1; m_jump = enc_jal('h804);
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R10 reset state, R6 reset jump target
        rd(12'h300);
        rd(12'h400);
        // R1 halt stores, repeated and out of range
        store(12'h100, 0);
        store(12'h100, 2);
        store(12'h100, 0);
        store(12'h100, 7);
        // R9 no strobe and stray offsets
        bus_we = 1; bus_addr = 12'h108; bus_be = 0; bus_wdata = 0; cyc();
        store(12'h300, 32'hDEAD_BEEF);
        store(12'h110, 2);
        rd(12'h300); rd(12'h104); rd(12'h404); rd(12'h800);
        // R8 busy for hart not halted
        req(1, 0);
        rd(12'h300);
        // R7 release hart 0 to abstract area, watch ordering
        req_valid = 1; req_hart = 0; req_dest = 0; bus_addr = 12'h400; cyc();
        rd(12'h300);
        rd(12'h400);
        rd(12'h401);
        req(2, 1);                  // R8 blocked by pending go
        store(12'h104, 0);          // R5
        rd(12'h400);
        // R3 exception then cleared by accepted request
        store(12'h10C, 0);
        rd(12'h300);
        req(2, 1);
        rd(12'h400); rd(12'h400);
        store(12'h104, 0);
        // R3 exception store in the same cycle as an acceptance
        req_valid = 1; req_hart = 0; req_dest = 2;
        bus_we = 1; bus_addr = 12'h10C; bus_be = 4'h1; bus_wdata = 0; cyc();
        // R5 going store while release in flight
        store(12'h104, 0);
        rd(12'h400); rd(12'h300);
        store(12'h104, 0);
        // R2 resume store clears halted
        store(12'h108, 0);
        rd(12'h400);
        req(0, 1);
        // dest code 3 maps to resume
        req(2, 3);
        rd(12'h300); rd(12'h400); rd(12'h400);
        store(12'h104, 0);
        store(12'h108, 2);
        store(12'h108, 9);
        store(12'h100, 3);
        req(3, 1);
        rd(12'h300); rd(12'h400);
        store(12'h104, 0);
        rd(12'h400);
        #1;
        compare();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule